// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flag

An 8-bit up-counting watchdog. Software arms it through a small control register and keeps it quiet by rewriting the count, normally with zero, before the count wraps. The counter only advances on cycles where an external prescale tick is high and the enable bit is set. When it wraps from all-ones to zero, the outcome depends on the mode bits:

- **Interval mode:** a one-cycle interrupt pulse.
- **Watchdog mode, NMI selected:** a one-cycle non-maskable interrupt request.
- **Watchdog mode, reset selected:** an internal reset pulse of fixed length.

A reset-cause flag tells software whether the last reset came from the external pin or from the watchdog. When both resets land together, the pin reset wins.

The register port is plain and carries no back-pressure. A write is accepted on every clock edge where `wr_en` is high, and a read is a combinational mux selected by `rd_sel`. There is no valid/ready stream at this block's edge, because every access completes in one cycle.

Top module: `wdog_timer`

## Requirements
- R1: While `pin_rst_n` is low, the control register reads 0x00, the count reads 0x00, `int_rst`, `nmi_req` and `itv_irq` are 0, and the reset-cause flag (bit 0 of selector 2) reads 1.
- R2: The count increments by one on each clock edge where `tick` is 1 and enable (control bit 0) is 1. After a preload of value v, the wrap from 0xFF to 0x00 happens on the (256−v)-th such edge.
- R3: The count holds its value on edges where `tick` is 0 or enable is 0.
- R4: In watchdog mode (control bit 1 = 1) with reset selected (control bit 2 = 1), a wrap drives `int_rst` high for exactly 518 clock cycles, starting with the cycle after the wrap edge. `nmi_req` stays low.
- R5: In watchdog mode with control bit 2 = 0, a wrap produces a one-cycle pulse on `nmi_req` and no `int_rst`.
- R6: In interval mode (control bit 1 = 0), a wrap produces a one-cycle pulse on `itv_irq`, with no `nmi_req` and no `int_rst`.
- R7: The overflow flag (control bit 3) is set by any wrap. A control write with bit 3 = 0 clears it. A write with bit 3 = 1 leaves it unchanged.
- R8: While `int_rst` is high, the count stays at 0 and count writes are ignored. When `int_rst` ends, the overflow flag and the reset-cause flag are 0, and control bits 0 to 2 are kept.
- R9: If `pin_rst_n` is low on the edge where a reset-mode wrap would occur, the pin reset takes priority: `int_rst` stays low and the reset-cause flag is 1.
- R10: A count write on the same edge as a tick loads the written value. Rewriting the count at regular intervals prevents any wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 count |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 control, 1 count, 2 reset-cause flag |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 1 | Prescale clock-enable |
| int_rst | output | 1 | Internal reset output |
| nmi_req | output | 1 | NMI request pulse |
| itv_irq | output | 1 | Interval interrupt pulse |

## Verification
Register writes are visible on `rd_data` one sample after the edge that took them, because reads are combinational. `itv_irq`, `nmi_req` and the rising edge of `int_rst` all appear in the first sample after the wrap edge. After a preload of v with ticks held high, that is 256−v edges after the write edge. The bench samples 1 ns after each rising edge and counts edges from the write, so an off-by-one in the tick gating or the output register changes the measured number. The reset pulse is measured by counting high samples, and the flags are read in the first sample after it falls.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Register selector codes shared by the read and write ports.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_SRC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Control register fields, most significant first (bit 3 .. bit 0).
  typedef struct packed {
    logic ovf;   // bit 3: overflow flag
    logic rsel;  // bit 2: 1 = reset on wrap, 0 = NMI on wrap
    logic wdm;   // bit 1: 1 = watchdog mode, 0 = interval mode
    logic tme;   // bit 0: timer enable
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tme,
  input  logic             tick,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic adv;

  // Hold has priority, then a write, then a tick.
  assign adv  = tme && tick && !hold && !wr_en;
  assign wrap = adv && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (hold)  cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (adv)   cnt <= cnt + ONE;
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_en && !(tme && tick)) |=> $stable(cnt)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_en && tme && tick) |=> (cnt == $past(cnt) + ONE)); // R2
  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0)); // R8
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 518
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LOAD = LW'(LEN);
  localparam logic [LW-1:0] ONE  = LW'(1);

  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (start)      left <= LOAD;
    else if (left != '0) left <= left - ONE;
  end

  assign active = (left != '0);
  assign done   = (left == ONE);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active); // R4
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !active); // R4
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ctl_t wr_val,
  input  logic ovf_set,
  input  logic wd_done,
  output ctl_t ctl,
  output logic xrst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      xrst <= 1'b1;
    end else begin
      if (wr_en) begin
        ctl.tme  <= wr_val.tme;
        ctl.wdm  <= wr_val.wdm;
        ctl.rsel <= wr_val.rsel;
      end

      // Set wins over both ways of clearing.
      if (ovf_set)                    ctl.ovf <= 1'b1;
      else if (wd_done)               ctl.ovf <= 1'b0;
      else if (wr_en && !wr_val.ovf)  ctl.ovf <= 1'b0;

      if (wd_done) xrst <= 1'b0;
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ctl.ovf); // R7
  AST_SRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wd_done |=> !xrst); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RST_LEN = 518
) (
  input  logic             clk,
  input  logic             pin_rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic             tick,
  output logic             int_rst,
  output logic             nmi_req,
  output logic             itv_irq
);
  ctl_t             ctl;
  logic             xrst;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             wd_done;
  logic             rst_start;
  logic             wr_ctl;
  logic             wr_cnt;

  assign wr_ctl    = wr_en && (wr_sel == SEL_CTRL);
  assign wr_cnt    = wr_en && (wr_sel == SEL_CNT);
  assign rst_start = wrap && ctl.wdm && ctl.rsel;

  wdog_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (pin_rst_n),
    .wr_en   (wr_ctl),
    .wr_val  (ctl_t'(wr_data[CTL_W-1:0])),
    .ovf_set (wrap),
    .wd_done (wd_done),
    .ctl     (ctl),
    .xrst    (xrst)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (pin_rst_n),
    .tme     (ctl.tme),
    .tick    (tick),
    .hold    (int_rst),
    .wr_en   (wr_cnt),
    .wr_data (wr_data),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  wdog_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (pin_rst_n),
    .start  (rst_start),
    .active (int_rst),
    .done   (wd_done)
  );

  always_ff @(posedge clk or negedge pin_rst_n) begin
    if (!pin_rst_n) begin
      nmi_req <= 1'b0;
      itv_irq <= 1'b0;
    end else begin
      nmi_req <= wrap && ctl.wdm && !ctl.rsel;
      itv_irq <= wrap && !ctl.wdm;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_data = CNT_W'(ctl);
      SEL_CNT:  rd_data = cnt;
      SEL_SRC:  rd_data = CNT_W'(xrst);
      default:  rd_data = '0;
    endcase
  end

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!pin_rst_n)
    nmi_req |=> !nmi_req); // R5
  AST_NMI_NO_RST: assert property (@(posedge clk) disable iff (!pin_rst_n)
    nmi_req |-> !int_rst); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!pin_rst_n)
    itv_irq |-> (!nmi_req && !int_rst)); // R6
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       pin_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       int_rst, nmi_req, itv_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk       (clk),
    .pin_rst_n (pin_rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .tick      (tick),
    .int_rst   (int_rst),
    .nmi_req   (nmi_req),
    .itv_irq   (itv_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive a write so that it lands on the next rising edge;
  // return 1 ns after that edge.
  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_sel = sel; #1;
    v = int'(rd_data);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n, w, seen;

    // R1: reset state
    repeat (3) @(posedge clk); #1;
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd2, v); check("R1 src", v, 1);
    check("R1 outs", int'({int_rst, nmi_req, itv_irq}), 0);
    @(negedge clk); pin_rst_n = 1'b1;

    // R2/R6: sweep every preload in interval mode
    wr(2'd0, 8'h01);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); tick = 1'b1;
      wr(2'd1, 8'(p));
      n = 0;
      while (!itv_irq && n < 300) begin step(); n++; end
      tick = 1'b0;
      check("R2 wrap edges", n, 256 - p);
      check("R6 no nmi/rst", int'({nmi_req, int_rst}), 0);
      step();
      check("R6 irq one cycle", int'(itv_irq), 0);
    end
    rd(2'd1, v); check("R2 count after wrap", v, 0);

    // R7: overflow flag set, write 1 keeps, write 0 clears
    rd(2'd0, v); check("R7 ovf set", (v >> 3) & 1, 1);
    wr(2'd0, 8'h09);
    rd(2'd0, v); check("R7 write1 keeps", v, 8'h09);
    wr(2'd0, 8'h01);
    rd(2'd0, v); check("R7 write0 clears", v, 8'h01);

    // R3: gating by tick and enable
    wr(2'd1, 8'h40);
    repeat (20) step();
    rd(2'd1, v); check("R3 tick low holds", v, 8'h40);
    tick = 1'b1;
    repeat (5) step();
    tick = 1'b0;
    rd(2'd1, v); check("R2 five ticks", v, 8'h45);
    wr(2'd0, 8'h00);
    tick = 1'b1;
    repeat (20) step();
    tick = 1'b0;
    rd(2'd1, v); check("R3 enable low holds", v, 8'h45);

    // R5: NMI mode
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hFF);
    tick = 1'b1;
    step();
    tick = 1'b0;
    check("R5 nmi pulse", int'(nmi_req), 1);
    check("R5 no int_rst", int'(int_rst), 0);
    check("R5 no irq", int'(itv_irq), 0);
    rd(2'd0, v); check("R7 ovf on nmi wrap", (v >> 3) & 1, 1);
    step();
    check("R5 nmi one cycle", int'(nmi_req), 0);

    // R10: write wins over tick; periodic kicks prevent a wrap
    wr(2'd0, 8'h07);
    tick = 1'b1;
    wr(2'd1, 8'h10);
    rd(2'd1, v); check("R10 write beats tick", v, 8'h10);
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      wr(2'd1, 8'h00);
      for (int c = 0; c < 200; c++) begin
        step();
        if (nmi_req || int_rst || itv_irq) seen++;
      end
    end
    tick = 1'b0;
    check("R10 no wrap", seen, 0);
    rd(2'd1, v); check("R10 count", v, 200);

    // R4/R8: reset-mode wrap
    wr(2'd1, 8'hFE);
    tick = 1'b1;
    n = 0;
    while (!int_rst && n < 10) begin step(); n++; end
    check("R4 start edge", n, 2);
    w = 1; seen = 0;
    while (int_rst && w < 700) begin
      if (w == 50) begin rd(2'd0, v); check("R8 ovf during", (v >> 3) & 1, 1); end
      if (w == 100) begin @(negedge clk); wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h55; end
      step();
      wr_en = 1'b0;
      if (nmi_req) seen++;
      if (w == 100) begin rd(2'd1, v); check("R8 write ignored", v, 0); end
      if (int_rst) w++;
    end
    check("R4 pulse width", w, 518);
    check("R4 no nmi", seen, 0);
    rd(2'd1, v); check("R8 count zero", v, 0);
    tick = 1'b0;
    rd(2'd0, v); check("R8 ctrl kept, ovf clear", v, 8'h07);
    rd(2'd2, v); check("R8 src cleared", v, 0);

    // R9: pin reset on the wrap edge wins
    wr(2'd1, 8'hFF);
    @(negedge clk); tick = 1'b1; pin_rst_n = 1'b0;
    step();
    @(negedge clk); tick = 1'b0; pin_rst_n = 1'b1;
    #1;
    check("R9 no int_rst", int'(int_rst), 0);
    rd(2'd2, v); check("R9 src set", v, 1);
    rd(2'd0, v); check("R1 ctrl after pin", v, 0);
    rd(2'd1, v); check("R1 count after pin", v, 0);
    step();
    check("R9 still no int_rst", int'(int_rst), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule